// File: doc/BRIEF.md
# Shared Private Window Address Decoder

This block sits in front of a 4 KB region that every processor in a small cluster sees at the same address. It decodes the low twelve address bits of each access. It serves a handful of cluster-control registers itself. Every other access is steered to one of two downstream families: the per-processor interrupt interfaces, and the per-processor timer/watchdog pairs. For each family, one window acts as an alias that always lands on the processor making the request. A run of explicit windows, one per processor, lets any processor reach a neighbour's copy.

The decoder drives a select, a target index and a local offset to each family. These outputs are combinational in the cycle of the access, so the downstream blocks see the write strobe and write data on the bus directly. Every access receives a registered response one cycle later: a valid flag, an error flag and read data. That read data comes from the block's own registers or from the downstream read data captured in the access cycle. Windows that belong to processors the cluster does not have are absorbed without an error. A parameter sets how many processors are present.

Top module: `prv_window_decode`

## Requirements
- R1: Only address bits [11:0] take part in decoding; the upper address bits have no effect on selects, indices, offsets or responses.
- R2: The control register at offset 0x000 comes out of reset as 0. A write stores only wdata bit 0, and a read returns that bit in bit 0 with every other bit 0.
- R3: A read of offset 0x004 returns ((2^N)-1)<<4 | (N-1), where N is the number of processors. Reads of 0x008 and 0x00C return 0. A write to 0x00C is accepted, raises no error and leaves the control register unchanged.
- R4: The following raise the error flag with read data 0: any other offset in 0x000–0x0FF, a write to 0x004 or 0x008, and any access in 0xB00–0xFFF.
- R5: An access in 0x100–0x1FF selects the interrupt interface of the requesting processor, and forwards offset bits [7:0].
- R6: An access in 0x200–0x5FF selects the interrupt interface of processor (offset[11:8] − 2), and forwards offset bits [7:0].
- R7: An access in 0x600–0x6FF selects timer instance {requester, offset[5]}, where bit 0 = 1 means the watchdog. It forwards offset bits [3:0].
- R8: An access in 0x700–0xAFF selects timer instance {offset[11:8] − 7, offset[5]}, and forwards offset bits [3:0].
- R9: When an explicit window names a processor index at or above N, no select is raised, the error flag stays low, a read returns 0, and a write reaches no downstream block.
- R10: Every access (read or write strobe high) is answered by rsp_valid exactly one cycle later. A read returns the downstream data presented in the access cycle, and a write returns read data 0. A cycle with no access produces no response in the following cycle.
- R11: Selects are raised only in a cycle in which bus_rd or bus_wr is high, and at most one select is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Access address; only bits [11:0] are decoded |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the requesting processor |
| gic_rdata | input | 32 | Read data from the selected interrupt interface, same cycle |
| tmr_rdata | input | 32 | Read data from the selected timer instance, same cycle |
| gic_sel | output | 1 | Interrupt interface select |
| gic_cpu | output | 2 | Processor whose interrupt interface is selected |
| gic_ofs | output | 8 | Register offset inside the interrupt interface window |
| tmr_sel | output | 1 | Timer family select |
| tmr_idx | output | 3 | Timer instance: processor × 2 + watchdog bit |
| tmr_ofs | output | 4 | Register offset inside the timer instance |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Previous access hit an undefined location |
| rsp_rdata | output | 32 | Read data for the previous cycle's read |

## Verification
The assertions assume that bus_rd and bus_wr are never high together, and that req_cpu always names a processor below N. The absent-bank and one-hot properties are only meaningful under those two conditions. The random stimulus picks at most one strobe per access, and draws the requester only from 0 to N−1. The bench builds the block with three processors so that the fourth bank of each family is absent. It biases addresses toward the cluster-control offsets and window edges, and randomizes the upper address bits to expose any dependence on them.

// File: rtl/prv_pkg.sv
package prv_pkg;

    localparam int DATA_W  = 32;
    localparam int OFS_W   = 12;
    localparam int WIN_W   = 8;
    localparam int NIB_W   = OFS_W - WIN_W;
    localparam int TREG_W  = 4;
    localparam int SUB_BIT = 5;
    localparam int MAX_CPU = 4;
    localparam int CPU_W   = $clog2(MAX_CPU);
    localparam int TIDX_W  = CPU_W + 1;

    // window numbering (offset[11:8]); order defines the map
    localparam int NIB_SCU       = 0;
    localparam int NIB_GIC_SELF  = NIB_SCU + 1;
    localparam int NIB_GIC_BANK  = NIB_GIC_SELF + 1;
    localparam int NIB_TMR_SELF  = NIB_GIC_BANK + MAX_CPU;
    localparam int NIB_TMR_BANK  = NIB_TMR_SELF + 1;
    localparam int NIB_END       = NIB_TMR_BANK + MAX_CPU;

    // cluster-control register offsets
    localparam logic [WIN_W-1:0] CC_CTRL  = 8'h00;
    localparam logic [WIN_W-1:0] CC_CFG   = 8'h04;
    localparam logic [WIN_W-1:0] CC_STAT  = 8'h08;
    localparam logic [WIN_W-1:0] CC_INVAL = 8'h0C;

    typedef enum logic [2:0] {
        TGT_CC,
        TGT_GIC,
        TGT_TMR,
        TGT_ABSENT,
        TGT_ERR
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [CPU_W-1:0] cpu;
        logic             sub;
        logic [WIN_W-1:0] loff;
    } route_t;

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] mask;
        mask = (DATA_W'(1) << n) - DATA_W'(1);
        return (mask << 4) | DATA_W'(n - 1);
    endfunction

endpackage

// File: rtl/prv_route.sv
module prv_route
    import prv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [CPU_W-1:0] req_cpu,
    output route_t           rt
);

    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] bank;
    logic [NIB_W-1:0] tbank;

    assign nib   = ofs[OFS_W-1:WIN_W];
    assign bank  = nib - NIB_W'(NIB_GIC_BANK);
    assign tbank = nib - NIB_W'(NIB_TMR_BANK);

    always_comb begin
        rt.tgt  = TGT_ERR;
        rt.cpu  = '0;
        rt.sub  = ofs[SUB_BIT];
        rt.loff = ofs[WIN_W-1:0];
        if (nib == NIB_W'(NIB_SCU)) begin
            rt.tgt = TGT_CC;
        end else if (nib == NIB_W'(NIB_GIC_SELF)) begin
            rt.tgt = TGT_GIC;
            rt.cpu = req_cpu;
        end else if (nib < NIB_W'(NIB_TMR_SELF)) begin
            rt.cpu = bank[CPU_W-1:0];
            rt.tgt = (bank < NIB_W'(NUM_CPU)) ? TGT_GIC : TGT_ABSENT;
        end else if (nib == NIB_W'(NIB_TMR_SELF)) begin
            rt.tgt = TGT_TMR;
            rt.cpu = req_cpu;
        end else if (nib < NIB_W'(NIB_END)) begin
            rt.cpu = tbank[CPU_W-1:0];
            rt.tgt = (tbank < NIB_W'(NUM_CPU)) ? TGT_TMR : TGT_ABSENT;
        end
    end

endmodule

// File: rtl/prv_cc_regs.sv
module prv_cc_regs
    import prv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              wr,
    input  logic [WIN_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CPU);

    logic ctrl_q;
    logic ctrl_we;
    logic [DATA_W-2:0] unused_wdata_hi;

    assign unused_wdata_hi = wdata[DATA_W-1:1];
    assign ctrl_we = hit && wr && (ofs == CC_CTRL);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= 1'b0;
        else if (ctrl_we) ctrl_q <= wdata[0];
    end

    always_comb begin
        rdata = '0;
        err   = 1'b0;
        if (hit) begin
            case (ofs)
                CC_CTRL:  rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
                CC_CFG:   begin rdata = CFG_VAL; err = wr; end
                CC_STAT:  err = wr;
                CC_INVAL: rdata = '0;
                default:  err = 1'b1;
            endcase
        end
    end

    // R2: the control bit moves only on a write to its own offset
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_q));

endmodule

// File: rtl/prv_window_decode.sv
module prv_window_decode
    import prv_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [DATA_W-1:0] gic_rdata,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic              gic_sel,
    output logic [CPU_W-1:0]  gic_cpu,
    output logic [WIN_W-1:0]  gic_ofs,
    output logic              tmr_sel,
    output logic [TIDX_W-1:0] tmr_idx,
    output logic [TREG_W-1:0] tmr_ofs,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              acc;
    route_t            rt;
    logic [DATA_W-1:0] cc_rdata;
    logic              cc_err;
    logic              cc_hit;
    logic [DATA_W-1:0] rdata_d;
    logic              err_d;
    logic [ADDR_W-OFS_W-1:0] unused_addr_hi;

    assign unused_addr_hi = bus_addr[ADDR_W-1:OFS_W];
    assign acc = bus_rd || bus_wr;

    prv_route #(.NUM_CPU(NUM_CPU)) route_i (
        .ofs     (bus_addr[OFS_W-1:0]),
        .req_cpu (req_cpu),
        .rt      (rt)
    );

    assign cc_hit = acc && (rt.tgt == TGT_CC);

    prv_cc_regs #(.NUM_CPU(NUM_CPU)) cc_i (
        .clk   (clk),
        .rst   (rst),
        .hit   (cc_hit),
        .wr    (bus_wr),
        .ofs   (rt.loff),
        .wdata (bus_wdata),
        .rdata (cc_rdata),
        .err   (cc_err)
    );

    assign gic_sel = acc && (rt.tgt == TGT_GIC);
    assign gic_cpu = rt.cpu;
    assign gic_ofs = rt.loff;
    assign tmr_sel = acc && (rt.tgt == TGT_TMR);
    assign tmr_idx = {rt.cpu, rt.sub};
    assign tmr_ofs = rt.loff[TREG_W-1:0];

    always_comb begin
        rdata_d = '0;
        err_d   = 1'b0;
        case (rt.tgt)
            TGT_CC:  begin err_d = cc_err; rdata_d = cc_err ? '0 : cc_rdata; end
            TGT_GIC: rdata_d = gic_rdata;
            TGT_TMR: rdata_d = tmr_rdata;
            TGT_ERR: err_d = 1'b1;
            default: rdata_d = '0;
        endcase
        if (!bus_rd) rdata_d = '0;
        if (!acc)    err_d   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_err   <= err_d;
            rsp_rdata <= rdata_d;
        end
    end

    // R10: each access is answered exactly one cycle later
    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid && !rsp_err);
    // R11: selects only during an access, never two at once
    p_sel_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(gic_sel && tmr_sel) && ((gic_sel || tmr_sel) -> acc));
    // R9: a select never names a processor the cluster lacks
    p_gic_present_r9: assert property (@(posedge clk) disable iff (rst)
        gic_sel |-> (int'(gic_cpu) < NUM_CPU));
    p_tmr_present_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_sel |-> (int'(tmr_idx[TIDX_W-1:1]) < NUM_CPU));
    // R4: an error response never follows a forwarded access
    p_err_unrouted_r4: assert property (@(posedge clk) disable iff (rst)
        (gic_sel || tmr_sel) |=> !rsp_err);

endmodule

// File: tb/prv_window_decode_tb.sv
module prv_window_decode_tb_top;
    import prv_pkg::*;

    localparam int N = 3;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [AW-1:0]     bus_addr;
    logic              bus_rd, bus_wr;
    logic [DATA_W-1:0] bus_wdata;
    logic [CPU_W-1:0]  req_cpu;
    logic [DATA_W-1:0] gic_rdata, tmr_rdata;
    logic              gic_sel, tmr_sel;
    logic [CPU_W-1:0]  gic_cpu;
    logic [WIN_W-1:0]  gic_ofs;
    logic [TIDX_W-1:0] tmr_idx;
    logic [TREG_W-1:0] tmr_ofs;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic model_ctrl = 1'b0;

    always #5 clk = ~clk;

    prv_window_decode #(.NUM_CPU(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .req_cpu(req_cpu),
        .gic_rdata(gic_rdata), .tmr_rdata(tmr_rdata),
        .gic_sel(gic_sel), .gic_cpu(gic_cpu), .gic_ofs(gic_ofs),
        .tmr_sel(tmr_sel), .tmr_idx(tmr_idx), .tmr_ofs(tmr_ofs),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected behaviour computed from the requirements
    typedef struct {
        logic gsel; logic [1:0] gcpu; logic [7:0] gofs;
        logic tsel; logic [2:0] tidx; logic [3:0] tofs;
        logic err;  logic [31:0] rdata; string req;
    } exp_t;

    function automatic exp_t predict(input logic [31:0] a, input logic rd, input logic wr,
                                     input logic [1:0] rq, input logic [31:0] gd,
                                     input logic [31:0] td, input logic ctl);
        exp_t e;
        int nib;
        logic [11:0] o;
        o = a[11:0];
        nib = int'(o[11:8]);
        e.gsel = 0; e.gcpu = 0; e.gofs = 0; e.tsel = 0; e.tidx = 0; e.tofs = 0;
        e.err = 0; e.rdata = 0; e.req = "R4";
        if (nib == 0) begin
            e.req = "R3";
            if (o == 12'h000) begin e.req = "R2"; e.rdata = {31'b0, ctl}; end
            else if (o == 12'h004) begin e.rdata = ((32'd1 << N) - 1) << 4 | (N - 1); e.err = wr; end
            else if (o == 12'h008) e.err = wr;
            else if (o == 12'h00C) e.rdata = 0;
            else begin e.err = 1; e.req = "R4"; end
            if (e.err) e.rdata = 0;
        end else if (nib == 1 || (nib >= 2 && nib <= 5)) begin
            int c;
            c = (nib == 1) ? int'(rq) : nib - 2;
            e.req = (nib == 1) ? "R5" : "R6";
            if (c < N) begin
                e.gsel = 1; e.gcpu = 2'(c); e.gofs = o[7:0]; e.rdata = gd;
            end else e.req = "R9";
        end else if (nib == 6 || (nib >= 7 && nib <= 10)) begin
            int c;
            c = (nib == 6) ? int'(rq) : nib - 7;
            e.req = (nib == 6) ? "R7" : "R8";
            if (c < N) begin
                e.tsel = 1; e.tidx = {2'(c), o[5]}; e.tofs = o[3:0]; e.rdata = td;
            end else e.req = "R9";
        end else begin
            e.err = 1;
        end
        if (!rd) e.rdata = 0;
        if (!(rd || wr)) begin e.gsel = 0; e.tsel = 0; e.err = 0; end
        return e;
    endfunction

    task automatic access(input logic [31:0] a, input logic rd, input logic wr,
                          input logic [31:0] wd, input logic [1:0] rq);
        exp_t e;
        @(negedge clk);
        chk("R10", "idle gives no response", {31'b0, rsp_valid}, 32'd0);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; req_cpu = rq;
        gic_rdata = $urandom; tmr_rdata = $urandom;
        #1;
        e = predict(a, rd, wr, rq, gic_rdata, tmr_rdata, model_ctrl);
        chk(e.req, "gic_sel", {31'b0, gic_sel}, {31'b0, e.gsel});
        chk(e.req, "tmr_sel", {31'b0, tmr_sel}, {31'b0, e.tsel});
        chk("R11", "no double select", {31'b0, gic_sel & tmr_sel}, 32'd0);
        if (e.gsel) begin
            chk(e.req, "gic_cpu", {30'b0, gic_cpu}, {30'b0, e.gcpu});
            chk(e.req, "gic_ofs", {24'b0, gic_ofs}, {24'b0, e.gofs});
        end
        if (e.tsel) begin
            chk(e.req, "tmr_idx", {29'b0, tmr_idx}, {29'b0, e.tidx});
            chk(e.req, "tmr_ofs", {28'b0, tmr_ofs}, {28'b0, e.tofs});
        end
        if (wr && a[11:0] == 12'h000) model_ctrl = wd[0];
        @(negedge clk);
        chk("R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, rd | wr});
        chk(e.req, "rsp_err", {31'b0, rsp_err}, {31'b0, e.err});
        chk(e.req, "rsp_rdata", rsp_rdata, e.rdata);
        bus_rd = 0; bus_wr = 0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] hi;
        process::self().srandom(32'd1234);
        rst = 1; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0; req_cpu = 0;
        gic_rdata = 0; tmr_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk("R10", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R2", "reset rsp_rdata", rsp_rdata, 32'd0);

        // R2: reset value, bit 0 kept, upper bits dropped
        access(32'h0000_0000, 1, 0, 0, 0);
        access(32'h0000_0000, 0, 1, 32'hFFFF_FFFE, 1);
        access(32'h0000_0000, 1, 0, 0, 1);
        access(32'h0000_0000, 0, 1, 32'h8000_0001, 2);
        access(32'h0000_0000, 1, 0, 0, 2);
        // R3: configuration word, status, invalidate write leaves control alone
        access(32'h0000_0004, 1, 0, 0, 0);
        access(32'h0000_0008, 1, 0, 0, 0);
        access(32'h0000_000C, 0, 1, 32'h0, 0);
        access(32'h0000_000C, 1, 0, 0, 0);
        access(32'h0000_0000, 1, 0, 0, 0);
        // R4: undefined offsets and writes to read-only registers
        access(32'h0000_0004, 0, 1, 32'h1, 0);
        access(32'h0000_0008, 0, 1, 32'h1, 0);
        access(32'h0000_0010, 1, 0, 0, 0);
        access(32'h0000_00FF, 0, 1, 32'h1, 0);
        access(32'h0000_0B00, 1, 0, 0, 1);
        access(32'h0000_0FFC, 0, 1, 32'h5, 2);
        // R5/R6: alias and bank edges
        access(32'h0000_0100, 1, 0, 0, 2);
        access(32'h0000_01FF, 0, 1, 32'h3, 1);
        access(32'h0000_0200, 1, 0, 0, 2);
        access(32'h0000_04FC, 1, 0, 0, 0);
        // R9: absent fourth bank, both families
        access(32'h0000_0500, 1, 0, 0, 0);
        access(32'h0000_05F0, 0, 1, 32'h7, 0);
        access(32'h0000_0A20, 1, 0, 0, 1);
        access(32'h0000_0AFC, 0, 1, 32'h7, 1);
        // R7/R8: timer and watchdog halves
        access(32'h0000_0600, 1, 0, 0, 2);
        access(32'h0000_062C, 1, 0, 0, 1);
        access(32'h0000_0700, 0, 1, 32'h9, 0);
        access(32'h0000_0924, 1, 0, 0, 0);
        // R1: upper address bits ignored
        access(32'hFFFF_F000, 1, 0, 0, 0);
        access(32'hABCD_E004, 1, 0, 0, 0);
        access(32'h1234_5834, 1, 0, 0, 1);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic rd;
            logic wr;
            int k;
            hi = $urandom;
            k = $urandom_range(0, 3);
            if (k == 0) a = {hi[31:12], 4'h0, 4'h0, 2'b00, hi[1:0], 2'b00};
            else        a = {hi[31:12], 12'($urandom)};
            k = $urandom_range(0, 4);
            rd = (k < 2);
            wr = (k >= 2 && k < 4);
            access(a, rd, wr, $urandom, 2'($urandom_range(0, N - 1)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule